// File: doc/BRIEF.md
# I2C Target Register File

This block is an I2C target that sits on a two-wire bus and gives the bus controller access to a small register file of twenty bytes, at word addresses 00h to 13h. The block answers to one fixed 7-bit device address. It samples SCL and SDA with a faster system clock through two-flop synchronizers. It drives the bus only through an open-drain pull-low enable, which the pad logic turns into a low level on SDA.

A transfer begins with an address byte. A write sends a word address next, which loads an internal byte pointer. Each data byte after that is stored at the pointer, and the pointer then steps forward. A read sends bytes from the pointer, one after another, for as long as the controller acknowledges them. The pointer survives between transfers. A read that carries no word address therefore continues from where the last transfer stopped. A random read sets the pointer with a write-mode word address, then issues a repeated START and a read-mode address byte.

The pointer steps from the last register back to 00h in both directions. Clock stretching, general call and 10-bit addressing are not handled.

Top module: `i2c_regfile_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits are 1101000. Bit 0 of that byte selects the direction: 1 is a read and 0 is a write. On any other address it never pulls SDA low and ignores the bus until the next START or STOP.
- R2: In a write, the byte after the address byte is the word address and loads the pointer. Each later data byte is stored at the pointer, and the pointer then increments. The block acknowledges every one of these bytes.
- R3: After reset the pointer is 00h. A read that has no word address starts at the pointer, and the pointer keeps its value across STOP and START.
- R4: A random read works as follows: a write-mode address byte, a word address, a repeated START, then a read-mode address byte. The data then starts at that word address.
- R5: In a read the block sends the byte at the pointer and increments the pointer. It goes on sending while the controller acknowledges in the ninth clock. After a NACK it releases SDA, and the pointer is left at the last byte sent plus one.
- R6: When the pointer steps past 13h it becomes 00h, in both reads and writes.
- R7: A word address above 13h is accepted and acknowledged. Data written there is discarded, a read there returns 00h, and the next step of the pointer goes to 00h.
- R8: After reset all twenty registers read 00h and SDA is released.
- R9: A START or STOP in the middle of a byte abandons that byte without storing it. A START then waits for a new address byte.
- R10: The block changes its pull-low output only while SCL is low, and holds its ACK through the whole ninth SCL high period. Data is sent and received MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad (wired bus value) |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A wrong pointer shows up at the pins at the next read, either in the same transfer or in a later current-address read. That read returns a byte other than the one the model predicts. A bad decode of the address or of the bit count shows up in the ninth clock of the byte that is affected, as a missing or stray ACK. A START or STOP that is detected wrongly shows up at once, as an ACK lost on the next address byte. The stimulus is a fixed-seed random mix of writes, random reads and current-address reads over the whole address range, including addresses past 13h. It runs together with directed cases for wrap, foreign addresses and an aborted byte. A side monitor on the pull output catches any change made while SCL is high.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
// Shared types for the I2C target register file.
// Assumes: nothing beyond IEEE 1800-2017.
package i2cr_pkg;

    // Protocol engine state; ST_ACK covers every ninth clock the target drives.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } eng_state_t;

endpackage

// File: rtl/i2cr_line_sync.sv
`timescale 1ns/1ps
// Synchronizes SCL and SDA into the system clock and derives the bus events.
// Assumes: SCL/SDA are slow against clk, so each edge lasts at least one cycle.
module i2cr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one delayed copy; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronized levels.
    always_comb begin
        scl_s     = scl_q[STAGES-1];
        sda_s     = sda_q[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_evt, stop_evt, scl_rise, scl_fall})); // R9

endmodule

// File: rtl/i2cr_regbank.sv
`timescale 1ns/1ps
// Byte register file with one synchronous write port and one combinational read.
// Assumes: addresses at or beyond REG_COUNT read as zero and are never written.
module i2cr_regbank #(
    parameter int REG_COUNT = 20,
    parameter int AW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data
);
    logic [7:0] regs [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        // One byte register; cleared by reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= 8'h00;
            else if (wr_en && addr == AW'(g))
                regs[g] <= wr_data;
        end
    end

    // Read mux; any address without a register returns zero.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < REG_COUNT; i++)
            if (addr == AW'(i)) rd_data = regs[i];
    end

    AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (addr < AW'(REG_COUNT))); // R7

endmodule

// File: rtl/i2cr_engine.sv
`timescale 1ns/1ps
// Byte-level I2C target protocol: address match, pointer, write and read flows.
// Assumes: synchronized bus levels and single-cycle event strobes from the
// line synchronizer; drives SDA only through pull_o and only while SCL is low.
module i2cr_engine
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'b1101000,
    parameter int         REG_COUNT = 20,
    parameter int         AW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [AW-1:0] ptr_o,
    output logic [7:0]    wr_data,
    output logic          pull_o
);
    localparam logic [AW-1:0] LAST = AW'(REG_COUNT - 1);

    eng_state_t    state, nxt_state;
    logic [3:0]    cnt;
    logic [7:0]    shreg;
    logic [AW-1:0] ptr, ptr_next;
    logic          mack;
    logic          byte_end;

    // Pointer step with wrap; anything at or past the last register goes to 0.
    always_comb begin
        ptr_next = (ptr >= LAST) ? '0 : ptr + 1'b1;
        byte_end = scl_fall && (cnt == 4'd8) && !start_evt && !stop_evt;
        wr_en    = (state == ST_WDATA) && byte_end && (ptr <= LAST);
        ptr_o    = ptr;
        wr_data  = shreg;
    end

    // Protocol state machine, bit counter, shifter, pointer and pull-low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            nxt_state <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            ptr       <= '0;
            mack      <= 1'b0;
            pull_o    <= 1'b0;
        end else if (start_evt) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            pull_o <= 1'b0;
        end else if (stop_evt) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            pull_o <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_end) begin
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                nxt_state <= shreg[0] ? ST_RDATA : ST_WADDR;
                                pull_o    <= 1'b1;
                                state     <= ST_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else begin
                            if (state == ST_WADDR) ptr <= shreg;
                            else                   ptr <= ptr_next;
                            nxt_state <= ST_WDATA;
                            pull_o    <= 1'b1;
                            state     <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (nxt_state == ST_RDATA) begin
                            shreg  <= rd_data;
                            pull_o <= ~rd_data[7];
                            ptr    <= ptr_next;
                        end else begin
                            pull_o <= 1'b0;
                        end
                        state <= nxt_state;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            pull_o <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            pull_o <= ~shreg[6];
                            shreg  <= {shreg[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        cnt <= '0;
                        if (mack) begin
                            shreg  <= rd_data;
                            pull_o <= ~rd_data[7];
                            ptr    <= ptr_next;
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ; // ST_IDLE and ST_IGNORE wait for START or STOP
            endcase
        end
    end

    AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_end && shreg[7:1] != DEV_ADDR)
            |=> (!pull_o && state == ST_IGNORE)); // R1
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_o != $past(pull_o))
            |-> (!$past(scl_s) || $past(start_evt) || $past(stop_evt))); // R10
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && pull_o && !scl_fall && !start_evt && !stop_evt)
            |=> pull_o); // R10
    AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_fall && mack && ptr >= LAST
            && !start_evt && !stop_evt) |=> (ptr == '0)); // R6
    AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_ADDR && cnt == 4'd0 && !pull_o)); // R9

endmodule

// File: rtl/i2c_regfile_target.sv
`timescale 1ns/1ps
// Top of the I2C target register file: synchronizer, protocol engine, registers.
// Assumes: clk runs many times faster than SCL; SDA is open drain at the pad.
module i2c_regfile_target #(
    parameter logic [6:0] DEV_ADDR    = 7'b1101000,
    parameter int         REG_COUNT   = 20,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int AW = 8;

    logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic          wr_en;
    logic [AW-1:0] ptr;
    logic [7:0]    wr_data, rd_data;

    i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2cr_engine #(.DEV_ADDR(DEV_ADDR), .REG_COUNT(REG_COUNT), .AW(AW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .ptr_o     (ptr),
        .wr_data   (wr_data),
        .pull_o    (sda_pull_o)
    );

    i2cr_regbank #(.REG_COUNT(REG_COUNT), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (ptr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

endmodule

// File: tb/i2c_regfile_target_tb.sv
`timescale 1ns/1ps
// Bench: bit-level bus controller model, reference register/pointer model,
// fixed-seed random transfers plus directed corner cases.
module i2c_regfile_target_tb;
    localparam int Q = 8;
    localparam int H = 16;
    localparam logic [7:0] AW_BYTE = 8'hD0;  // 1101000 + write
    localparam logic [7:0] AR_BYTE = 8'hD1;  // 1101000 + read

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic pull;
    wire  sda_bus;
    assign sda_bus = !(m_low || pull);

    always #2.5 clk = ~clk;

    i2c_regfile_target u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_pull_o (pull)
    );

    int checks = 0;
    int errors = 0;
    int r10_viol = 0;
    bit done = 1'b0;
    logic [7:0] model [20];
    logic [7:0] ptr_m;
    logic pull_prev = 1'b0;
    logic scl_prev = 1'b1;

    function automatic logic [7:0] nxt(input logic [7:0] p);
        return (p >= 8'd19) ? 8'd0 : p + 8'd1;
    endfunction

    function automatic logic [7:0] rdm(input logic [7:0] p);
        return (p <= 8'd19) ? model[p[4:0]] : 8'h00;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10 monitor: pull output must not move while SCL has been high.
    always @(negedge clk) begin
        if (rst_n && scl && scl_prev && pull !== pull_prev) r10_viol++;
        pull_prev = pull;
        scl_prev  = scl;
    end

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(H);
        m_low = 1'b1; tick(H);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(H);
        m_low = 1'b0; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; tick(Q);
            scl = 1'b1;    tick(H);
            scl = 1'b0;    tick(Q);
        end
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(2);
        a1 = !sda_bus; tick(H - 3);
        a2 = !sda_bus; tick(1);
        scl = 1'b0;   tick(Q);
        acked = a1 && a2;   // R10: ACK present early and late in the high phase
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        m_low = 1'b0;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(H / 2);
            b = {b[6:0], sda_bus};
            tick(H / 2);
            scl = 1'b0;
        end
        tick(Q);
        m_low = ack; tick(Q);
        scl = 1'b1;  tick(H);
        scl = 1'b0;  tick(Q);
        m_low = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] wa, input int n);
        bit a;
        logic [7:0] d;
        bus_start();
        send_byte(AW_BYTE, a); chk(a, "R1 address ack", a, 1);
        send_byte(wa, a);      chk(a, "R2 word address ack", a, 1);
        ptr_m = wa;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, a); chk(a, "R2 data ack", a, 1);
            if (ptr_m <= 8'd19) model[ptr_m[4:0]] = d;
            ptr_m = nxt(ptr_m);
        end
        bus_stop();
    endtask

    task automatic do_read(input bit rnd, input logic [7:0] wa, input int n,
                           input string req);
        bit a;
        logic [7:0] got;
        bus_start();
        if (rnd) begin
            send_byte(AW_BYTE, a); chk(a, "R4 write-mode address ack", a, 1);
            send_byte(wa, a);      chk(a, "R4 word address ack", a, 1);
            ptr_m = wa;
            bus_start();
        end
        send_byte(AR_BYTE, a); chk(a, "R1 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, got);
            chk(got == rdm(ptr_m), req, got, rdm(ptr_m));
            ptr_m = nxt(ptr_m);
        end
        bus_stop();
    endtask

    initial begin
        bit a;
        int op, n;
        logic [7:0] wa;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 20; i++) model[i] = 8'h00;
        ptr_m = 8'h00;
        tick(6);
        rst_n = 1'b1;
        tick(4);
        chk(pull == 1'b0, "R8 SDA released after reset", pull, 0);

        // R3/R8: current-address read from reset starts at 00h, all zero
        do_read(1'b0, 8'h00, 3, "R3 current read from reset");
        // R2: sequential write, then R4 random read back
        do_write(8'h05, 3);
        do_read(1'b1, 8'h05, 4, "R4 random read data");
        // R3: pointer persists across transfers; R5 NACK left it at last+1
        do_read(1'b0, 8'h00, 2, "R5 R3 continue after NACK");

        // R1: foreign addresses get no ACK and following bytes are ignored
        bus_start();
        send_byte(8'hA4, a); chk(!a, "R1 foreign address no ack", a, 0);
        send_byte(8'h00, a); chk(!a, "R1 bus ignored after mismatch", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD2, a); chk(!a, "R1 near-miss address no ack", a, 0);
        bus_stop();
        do_read(1'b0, 8'h00, 1, "R1 pointer untouched by foreign transfer");

        // R6: write and read wrapping past 13h
        do_write(8'h12, 3);
        do_read(1'b1, 8'h12, 4, "R6 wrap on read");
        do_read(1'b0, 8'h00, 1, "R6 pointer after wrap");

        // R7: word address beyond the register file
        do_write(8'h30, 1);
        do_read(1'b1, 8'h30, 2, "R7 out-of-range read then wrap");
        do_read(1'b1, 8'h13, 2, "R7 R6 top register unaffected");

        // R9: START in the middle of a data byte abandons it
        bus_start();
        send_byte(AW_BYTE, a); chk(a, "R9 address ack", a, 1);
        send_byte(8'h08, a);   chk(a, "R9 word address ack", a, 1);
        for (int i = 0; i < 4; i++) begin
            m_low = 1'b0; tick(Q);
            scl = 1'b1;   tick(H);
            scl = 1'b0;   tick(Q);
        end
        do_read(1'b1, 8'h08, 1, "R9 aborted byte not stored");
        // R9: STOP in the middle of a data byte, then fresh START works
        bus_start();
        send_byte(AW_BYTE, a); chk(a, "R9 address ack 2", a, 1);
        send_byte(8'h09, a);   chk(a, "R9 word address ack 2", a, 1);
        for (int i = 0; i < 3; i++) begin
            m_low = 1'b0; tick(Q);
            scl = 1'b1;   tick(H);
            scl = 1'b0;   tick(Q);
        end
        bus_stop();
        do_read(1'b1, 8'h09, 1, "R9 stop-aborted byte not stored");

        // Random mix over the full address range (R2 R3 R4 R5 R6 R7)
        for (int it = 0; it < 20; it++) begin
            op = int'($urandom % 3);
            wa = 8'($urandom % 24);
            n  = 1 + int'($urandom % 3);
            case (op)
                0:       do_write(wa, n);
                1:       do_read(1'b1, wa, n, "R4 random mix read");
                default: do_read(1'b0, 8'h00, n, "R3 random mix current read");
            endcase
        end

        chk(r10_viol == 0, "R10 pull changed while SCL high", r10_viol, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule